// File: doc/BRIEF.md
# Forth Extension Unit

This block is a multi-cycle execution unit that sits beside a small 8-bit accumulator processor and carries out a set of extra instructions aimed at a Forth runtime. X serves as the data-stack pointer. The stack holds 16-bit little-endian cells in page zero, with the high byte one address above the low byte. The unit can use a pointer on that stack as the base of a Y-indexed load or store. It can move X by two in either direction, copy the hardware stack pointer into Y, load A and Y together from a stack cell, jump through a Y-indexed table of 16-bit targets, and set, clear or test a single bit of a page-zero byte.

The surrounding core decodes an instruction and presents an operation code, a 16-bit operand, a bit index and its current A, X, Y, S, N, Z and PC. It then pulses `start`. The unit drives a synchronous single-port byte memory with one cycle of read latency. It raises `done` for one cycle when the operation is complete. At that point the register and flag outputs hold the results, and they stay there until the next accepted start.

Top module: `fx_unit`

## Requirements
- R1: While `rstN` is low and after it is released: `busy`, `done` and `memWe` are 0, and `aOut`, `xOut`, `yOut`, `pcOut`, `nOut`, `zOut` are 0.
- R2: `start` is accepted only while `busy` is 0. A `start` pulse, or a change of `opSel`, during an operation has no effect on that operation or its results.
- R3: Code 0 (indirect load) reads a little-endian pointer at page-zero address `operand[7:0]+X`. It adds Y to the pointer with full 16-bit carry and loads A from the resulting address. N and Z follow the new A. `done` comes 6 cycles after the start cycle.
- R4: Code 1 (indirect store) forms the same address as R3 and writes A there with exactly one write. The flags are unchanged. `done` comes 5 cycles after start.
- R5: Every page-zero address wraps modulo 256, including the +1 that reaches a high byte. Page-zero accesses put 0 on `memAddr[15:8]`.
- R6: Code 2 adds 2 to X and code 3 subtracts 2 from X, both modulo 256. N and Z follow the new X, and `done` comes 2 cycles after start.
- R7: Code 4 copies `sIn` into Y. N and Z follow the new Y, and A and X are unchanged. `done` comes 2 cycles after start.
- R8: Code 5 (paired load) loads A from page zero at `operand[7:0]+X` and Y from the next page-zero byte. N and Z follow Y, and `done` comes 4 cycles after start.
- R9: Code 6 (table jump) loads PC with the little-endian word at `operand+Y`, a 16-bit sum with carry. The flags are unchanged, and `done` comes 4 cycles after start.
- R10: Code 7 sets and code 8 clears bit `bitSel` of the page-zero byte at `operand[7:0]`. The other bits and the flags are kept, and `done` comes 3 cycles after start.
- R11: Code 9 sets Z when bit `bitSel` of the page-zero byte at `operand[7:0]` is 0 and clears it otherwise. N, the registers and memory are unchanged.
- R12: Codes 10 to 15 complete 2 cycles after start with no memory write and no change to any register or flag.
- R13: `done` is a single-cycle pulse. After it, the outputs hold their values while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| opSel | input | 4 | Operation code |
| operand | input | 16 | Instruction operand; low byte for page-zero forms |
| bitSel | input | 3 | Bit index for bit operations |
| aIn | input | 8 | Current A |
| xIn | input | 8 | Current X (data-stack pointer) |
| yIn | input | 8 | Current Y |
| sIn | input | 8 | Current hardware stack pointer (read only) |
| nIn | input | 1 | Current N flag |
| zIn | input | 1 | Current Z flag |
| pcIn | input | 16 | Current program counter |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| aOut | output | 8 | Resulting A |
| xOut | output | 8 | Resulting X |
| yOut | output | 8 | Resulting Y |
| pcOut | output | 16 | Resulting program counter |
| nOut | output | 1 | Resulting N flag |
| zOut | output | 1 | Resulting Z flag |
| memAddr | output | 16 | Memory address |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, valid one cycle after the address |

## Verification
The bench targets page-zero wrap at 0xFF. A design that carried into page one would fetch the pointer's high byte or Y's byte from 0x0100 rather than 0x0000. It also targets the carry into the high byte when Y is added to a pointer or table base, which a truncating adder would lose by landing in the wrong page. Stores, jumps and bit set/clear are run with both flags set or mixed, so that a unit which rewrote N or Z on those paths is caught. A start held high and an operation code changed in mid-operation check that the running instruction is neither restarted nor replaced by the new code. Exact cycle counts catch a sequencer that samples read data one cycle early or late.

// File: rtl/fx_pkg.sv
package fx_pkg;

  typedef enum logic [3:0] {
    OP_LDIND  = 4'd0,
    OP_STIND  = 4'd1,
    OP_XUP2   = 4'd2,
    OP_XDN2   = 4'd3,
    OP_S2Y    = 4'd4,
    OP_LDPAIR = 4'd5,
    OP_JTAB   = 4'd6,
    OP_BSET   = 4'd7,
    OP_BCLR   = 4'd8,
    OP_BTST   = 4'd9
  } fxOp_e;

  typedef enum logic [2:0] {
    AS_ZP, AS_ZPNEXT, AS_TAB, AS_TABNEXT, AS_EFF, AS_DIRECT
  } addrSel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDA, ST_RDB, ST_CAPB, ST_ACC, ST_FIN, ST_RMW, ST_DONE
  } fxState_e;

  typedef struct packed {
    logic     latch;
    addrSel_e addrSel;
    logic     memWe;
    logic     wrBit;
    logic     capLo;
    logic     capHi;
    logic     ldA;
    logic     ldPair;
    logic     ldPc;
    logic     xUp;
    logic     xDn;
    logic     s2y;
    logic     bitSet;
    logic     bitClr;
    logic     bitTest;
  } fxStrobe_t;

endpackage

// File: rtl/fx_ctrl.sv
module fx_ctrl
  import fx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] opSel,
  output logic       busy,
  output logic       done,
  output fxStrobe_t  stb
);

  fxState_e   state, stateNext;
  logic [3:0] opR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opR   <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && start) opR <= opSel;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  logic isPtrOp, isPairOp, isJmpOp, isBitOp, isRegOp;
  always_comb begin
    isPtrOp  = (opR == OP_LDIND) || (opR == OP_STIND);
    isPairOp = (opR == OP_LDPAIR);
    isJmpOp  = (opR == OP_JTAB);
    isBitOp  = (opR == OP_BSET) || (opR == OP_BCLR) || (opR == OP_BTST);
    isRegOp  = !(isPtrOp || isPairOp || isJmpOp || isBitOp);
  end

  always_comb begin
    stateNext   = state;
    stb         = '0;
    stb.addrSel = AS_ZP;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.latch = 1'b1;
          stateNext = ST_RDA;
        end
      end
      ST_RDA: begin
        if (isRegOp) begin
          stb.xUp   = (opR == OP_XUP2);
          stb.xDn   = (opR == OP_XDN2);
          stb.s2y   = (opR == OP_S2Y);
          stateNext = ST_DONE;
        end else if (isBitOp) begin
          stb.addrSel = AS_DIRECT;
          stateNext   = ST_RMW;
        end else begin
          stb.addrSel = isJmpOp ? AS_TAB : AS_ZP;
          stateNext   = ST_RDB;
        end
      end
      ST_RDB: begin
        stb.addrSel = isJmpOp ? AS_TABNEXT : AS_ZPNEXT;
        stb.capLo   = 1'b1;
        stateNext   = ST_CAPB;
      end
      ST_CAPB: begin
        stb.capHi  = isPtrOp;
        stb.ldPair = isPairOp;
        stb.ldPc   = isJmpOp;
        stateNext  = isPtrOp ? ST_ACC : ST_DONE;
      end
      ST_ACC: begin
        stb.addrSel = AS_EFF;
        stb.memWe   = (opR == OP_STIND);
        stateNext   = (opR == OP_STIND) ? ST_DONE : ST_FIN;
      end
      ST_FIN: begin
        stb.ldA   = 1'b1;
        stateNext = ST_DONE;
      end
      ST_RMW: begin
        stb.addrSel = AS_DIRECT;
        stb.bitSet  = (opR == OP_BSET);
        stb.bitClr  = (opR == OP_BCLR);
        stb.bitTest = (opR == OP_BTST);
        stb.memWe   = (opR != OP_BTST);
        stb.wrBit   = 1'b1;
        stateNext   = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R12
  write_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWe |-> busy);

endmodule

// File: rtl/fx_datapath.sv
module fx_datapath
  import fx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fxStrobe_t             stb,
  input  logic [2*DATA_W-1:0]   operand,
  input  logic [$clog2(DATA_W)-1:0] bitSel,
  input  logic [DATA_W-1:0]     aIn,
  input  logic [DATA_W-1:0]     xIn,
  input  logic [DATA_W-1:0]     yIn,
  input  logic [DATA_W-1:0]     sIn,
  input  logic                  nIn,
  input  logic                  zIn,
  input  logic [2*DATA_W-1:0]   pcIn,
  input  logic [DATA_W-1:0]     memRdata,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic                  memWe,
  output logic [DATA_W-1:0]     memWdata,
  output logic [DATA_W-1:0]     aOut,
  output logic [DATA_W-1:0]     xOut,
  output logic [DATA_W-1:0]     yOut,
  output logic [2*DATA_W-1:0]   pcOut,
  output logic                  nOut,
  output logic                  zOut
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(2);
  localparam logic [DATA_W-1:0] PAGE0 = '0;

  logic [DATA_W-1:0] aR, xR, yR, sR, ptrLo, ptrHi;
  logic [ADDR_W-1:0] pcR, opndR;
  logic [BIT_W-1:0]  bitR;
  logic              nR, zR;

  // page-zero arithmetic stays DATA_W wide so it wraps
  logic [DATA_W-1:0] zpBase, zpNext;
  logic [ADDR_W-1:0] tabAddr, tabNext, effAddr;
  always_comb begin
    zpBase  = opndR[DATA_W-1:0] + xR;
    zpNext  = zpBase + DATA_W'(1);
    tabAddr = opndR + {PAGE0, yR};
    tabNext = tabAddr + ADDR_W'(1);
    effAddr = {ptrHi, ptrLo} + {PAGE0, yR};
  end

  always_comb begin
    unique case (stb.addrSel)
      AS_ZP:      memAddr = {PAGE0, zpBase};
      AS_ZPNEXT:  memAddr = {PAGE0, zpNext};
      AS_TAB:     memAddr = tabAddr;
      AS_TABNEXT: memAddr = tabNext;
      AS_EFF:     memAddr = effAddr;
      AS_DIRECT:  memAddr = {PAGE0, opndR[DATA_W-1:0]};
      default:    memAddr = {PAGE0, opndR[DATA_W-1:0]};
    endcase
  end

  logic [DATA_W-1:0] bitMask, bitByte;
  always_comb begin
    for (int i = 0; i < DATA_W; i++) bitMask[i] = (bitR == BIT_W'(i));
    if (stb.bitSet)      bitByte = memRdata | bitMask;
    else if (stb.bitClr) bitByte = memRdata & ~bitMask;
    else                 bitByte = memRdata;
  end

  assign memWe    = stb.memWe;
  assign memWdata = stb.wrBit ? bitByte : aR;

  logic [DATA_W-1:0] xNext;
  always_comb begin
    xNext = xR;
    if (stb.xUp)      xNext = xR + STEP;
    else if (stb.xDn) xNext = xR - STEP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aR <= '0; xR <= '0; yR <= '0; sR <= '0;
      ptrLo <= '0; ptrHi <= '0;
      pcR <= '0; opndR <= '0; bitR <= '0;
      nR <= 1'b0; zR <= 1'b0;
    end else if (stb.latch) begin
      aR <= aIn; xR <= xIn; yR <= yIn; sR <= sIn;
      pcR <= pcIn; opndR <= operand; bitR <= bitSel;
      nR <= nIn; zR <= zIn;
    end else begin
      if (stb.capLo) ptrLo <= memRdata;
      if (stb.capHi) ptrHi <= memRdata;
      if (stb.ldA) begin
        aR <= memRdata;
        nR <= memRdata[DATA_W-1];
        zR <= (memRdata == '0);
      end
      if (stb.ldPair) begin
        aR <= ptrLo;
        yR <= memRdata;
        nR <= memRdata[DATA_W-1];
        zR <= (memRdata == '0);
      end
      if (stb.ldPc) pcR <= {memRdata, ptrLo};
      if (stb.xUp || stb.xDn) begin
        xR <= xNext;
        nR <= xNext[DATA_W-1];
        zR <= (xNext == '0);
      end
      if (stb.s2y) begin
        yR <= sR;
        nR <= sR[DATA_W-1];
        zR <= (sR == '0);
      end
      if (stb.bitTest) zR <= ~memRdata[bitR];
    end
  end

  assign aOut  = aR;
  assign xOut  = xR;
  assign yOut  = yR;
  assign pcOut = pcR;
  assign nOut  = nR;
  assign zOut  = zR;

  // R5
  zp_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.addrSel == AS_ZP || stb.addrSel == AS_ZPNEXT || stb.addrSel == AS_DIRECT)
      |-> (memAddr[ADDR_W-1:DATA_W] == '0));

  // R4
  store_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> ($stable(nR) && $stable(zR)));

  // R9
  jump_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldPc |=> ($stable(nR) && $stable(zR)));

endmodule

// File: rtl/fx_unit.sv
module fx_unit
  import fx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [3:0]             opSel,
  input  logic [2*DATA_W-1:0]    operand,
  input  logic [$clog2(DATA_W)-1:0] bitSel,
  input  logic [DATA_W-1:0]      aIn,
  input  logic [DATA_W-1:0]      xIn,
  input  logic [DATA_W-1:0]      yIn,
  input  logic [DATA_W-1:0]      sIn,
  input  logic                   nIn,
  input  logic                   zIn,
  input  logic [2*DATA_W-1:0]    pcIn,
  output logic                   busy,
  output logic                   done,
  output logic [DATA_W-1:0]      aOut,
  output logic [DATA_W-1:0]      xOut,
  output logic [DATA_W-1:0]      yOut,
  output logic [2*DATA_W-1:0]    pcOut,
  output logic                   nOut,
  output logic                   zOut,
  output logic [2*DATA_W-1:0]    memAddr,
  output logic                   memWe,
  output logic [DATA_W-1:0]      memWdata,
  input  logic [DATA_W-1:0]      memRdata
);

  fxStrobe_t stb;

  fx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .busy(busy), .done(done), .stb(stb)
  );

  fx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .operand(operand), .bitSel(bitSel),
    .aIn(aIn), .xIn(xIn), .yIn(yIn), .sIn(sIn),
    .nIn(nIn), .zIn(zIn), .pcIn(pcIn),
    .memRdata(memRdata), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .aOut(aOut), .xOut(xOut), .yOut(yOut), .pcOut(pcOut),
    .nOut(nOut), .zOut(zOut)
  );

  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWe);

endmodule

// File: tb/tb_fx_unit.sv
module tb_fx_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] C_LDIND = 4'd0, C_STIND = 4'd1, C_XUP = 4'd2, C_XDN = 4'd3,
                         C_S2Y = 4'd4, C_PAIR = 4'd5, C_JTAB = 4'd6, C_BSET = 4'd7,
                         C_BCLR = 4'd8, C_BTST = 4'd9;

  logic clk = 0, rstN = 0, start = 0;
  logic [3:0] opSel = 0;
  logic [15:0] operand = 0, pcIn = 0, pcOut, memAddr;
  logic [2:0] bitSel = 0;
  logic [7:0] aIn = 0, xIn = 0, yIn = 0, sIn = 0;
  logic nIn = 0, zIn = 0;
  logic busy, done, nOut, zOut, memWe;
  logic [7:0] aOut, xOut, yOut, memWdata, memRdata;

  logic [7:0] mem [0:1023];
  int wrCnt = 0;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr[9:0]] <= memWdata;
      wrCnt <= wrCnt + 1;
    end
    memRdata <= mem[memAddr[9:0]];
  end

  fx_unit dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .operand(operand),
    .bitSel(bitSel), .aIn(aIn), .xIn(xIn), .yIn(yIn), .sIn(sIn),
    .nIn(nIn), .zIn(zIn), .pcIn(pcIn), .busy(busy), .done(done),
    .aOut(aOut), .xOut(xOut), .yOut(yOut), .pcOut(pcOut), .nOut(nOut), .zOut(zOut),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic setRegs(input logic [7:0] a, input logic [7:0] x, input logic [7:0] y,
                         input logic [7:0] s, input logic n, input logic z,
                         input logic [15:0] pc);
    aIn = a; xIn = x; yIn = y; sIn = s; nIn = n; zIn = z; pcIn = pc;
  endtask

  task automatic runOp(input logic [3:0] op, input logic [15:0] opnd, input logic [2:0] b,
                       input bit junk, output int cyc, output int wr);
    int w0;
    @(negedge clk);
    opSel = op; operand = opnd; bitSel = b; start = 1;
    w0 = wrCnt;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (junk) begin start = 1; opSel = C_XUP; end
      else start = 0;
      if (done) break;
      if (cyc > 50) break;
    end
    start = 0;
    wr = wrCnt - w0;
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && memWe == 0, "R1 idle", {busy, done, memWe}, 0);
    chk(aOut == 0 && xOut == 0 && yOut == 0 && pcOut == 0 && nOut == 0 && zOut == 0,
        "R1 regs", {aOut, xOut, yOut}, 0);
  endtask

  task automatic t_ldind();
    int c, w;
    mem[16'h30] = 8'h00; mem[16'h31] = 8'h02; mem[16'h205] = 8'h85;
    setRegs(8'h11, 8'h10, 8'h05, 8'hF0, 0, 1, 16'h4000);
    runOp(C_LDIND, 16'h0020, 0, 0, c, w);
    chk(aOut == 8'h85, "R3 load A", aOut, 8'h85);
    chk(nOut == 1 && zOut == 0, "R3 flags", {nOut, zOut}, 2'b10);
    chk(c == 6, "R3 cycles", c, 6);
    chk(w == 0 && xOut == 8'h10 && yOut == 8'h05, "R3 no side effect", w, 0);
    // pointer 0x01FF + Y 0x03 -> 0x0202 (carry into high byte)
    mem[16'h30] = 8'hFF; mem[16'h31] = 8'h01; mem[16'h202] = 8'h00; mem[16'h102] = 8'h77;
    setRegs(8'h11, 8'h10, 8'h03, 8'hF0, 1, 0, 16'h4000);
    runOp(C_LDIND, 16'h0020, 0, 0, c, w);
    chk(aOut == 8'h00 && zOut == 1 && nOut == 0, "R3 carry", aOut, 0);
  endtask

  task automatic t_stind();
    int c, w;
    mem[16'h40] = 8'h80; mem[16'h41] = 8'h02; mem[16'h290] = 8'h00;
    setRegs(8'h5A, 8'h38, 8'h10, 8'hF0, 1, 1, 16'h4000);
    runOp(C_STIND, 16'h0008, 0, 0, c, w);
    chk(mem[16'h290] == 8'h5A, "R4 store", mem[16'h290], 8'h5A);
    chk(w == 1, "R4 one write", w, 1);
    chk(nOut == 1 && zOut == 1, "R4 flags kept", {nOut, zOut}, 2'b11);
    chk(c == 5, "R4 cycles", c, 5);
  endtask

  task automatic t_wrap();
    int c, w;
    mem[16'hFF] = 8'h10; mem[16'h00] = 8'h03; mem[16'h100] = 8'hEE; mem[16'h310] = 8'h42;
    setRegs(8'h00, 8'h01, 8'h00, 8'hF0, 0, 0, 16'h0);
    runOp(C_LDIND, 16'h00FE, 0, 0, c, w);
    chk(aOut == 8'h42, "R5 pointer wrap", aOut, 8'h42);
    setRegs(8'h00, 8'h0F, 8'h00, 8'hF0, 0, 0, 16'h0);
    runOp(C_PAIR, 16'h00F0, 0, 0, c, w);
    chk(aOut == 8'h10 && yOut == 8'h03, "R5 pair wrap", {aOut, yOut}, 16'h1003);
  endtask

  task automatic t_xstep();
    int c, w;
    setRegs(8'h22, 8'hFF, 8'h33, 8'hF0, 1, 1, 16'h1);
    runOp(C_XUP, 0, 0, 0, c, w);
    chk(xOut == 8'h01 && nOut == 0 && zOut == 0, "R6 up wrap", xOut, 8'h01);
    chk(c == 2 && w == 0 && aOut == 8'h22, "R6 cycles", c, 2);
    setRegs(8'h22, 8'h01, 8'h33, 8'hF0, 0, 1, 16'h1);
    runOp(C_XDN, 0, 0, 0, c, w);
    chk(xOut == 8'hFF && nOut == 1 && zOut == 0, "R6 down wrap", xOut, 8'hFF);
    setRegs(8'h22, 8'h02, 8'h33, 8'hF0, 1, 0, 16'h1);
    runOp(C_XDN, 0, 0, 0, c, w);
    chk(xOut == 8'h00 && nOut == 0 && zOut == 1, "R6 zero", xOut, 0);
  endtask

  task automatic t_s2y();
    int c, w;
    setRegs(8'h44, 8'h55, 8'h00, 8'hF3, 0, 1, 16'h1);
    runOp(C_S2Y, 0, 0, 0, c, w);
    chk(yOut == 8'hF3 && nOut == 1 && zOut == 0, "R7 copy", yOut, 8'hF3);
    chk(aOut == 8'h44 && xOut == 8'h55 && c == 2, "R7 others kept", {aOut, xOut}, 16'h4455);
  endtask

  task automatic t_pair();
    int c, w;
    mem[16'h52] = 8'h7F; mem[16'h53] = 8'h00;
    setRegs(8'h00, 8'h02, 8'h99, 8'hF0, 1, 0, 16'h1);
    runOp(C_PAIR, 16'h0050, 0, 0, c, w);
    chk(aOut == 8'h7F && yOut == 8'h00, "R8 values", {aOut, yOut}, 16'h7F00);
    chk(zOut == 1 && nOut == 0 && c == 4, "R8 flags from Y", {zOut, nOut}, 2'b10);
  endtask

  task automatic t_jtab();
    int c, w;
    mem[16'h210] = 8'h34; mem[16'h211] = 8'h12;
    setRegs(8'h00, 8'h00, 8'h20, 8'hF0, 0, 1, 16'h0800);
    runOp(C_JTAB, 16'h01F0, 0, 0, c, w);
    chk(pcOut == 16'h1234, "R9 target", pcOut, 16'h1234);
    chk(nOut == 0 && zOut == 1 && c == 4 && w == 0, "R9 flags cycles", c, 4);
  endtask

  task automatic t_bits();
    int c, w;
    mem[16'h60] = 8'h00; mem[16'h61] = 8'hFF; mem[16'h62] = 8'h04;
    setRegs(8'h00, 8'h00, 8'h00, 8'hF0, 1, 1, 16'h0);
    runOp(C_BSET, 16'h0060, 3'd3, 0, c, w);
    chk(mem[16'h60] == 8'h08 && c == 3, "R10 set", mem[16'h60], 8'h08);
    chk(nOut == 1 && zOut == 1, "R10 flags kept", {nOut, zOut}, 2'b11);
    runOp(C_BCLR, 16'h0061, 3'd7, 0, c, w);
    chk(mem[16'h61] == 8'h7F && w == 1, "R10 clear", mem[16'h61], 8'h7F);
    setRegs(8'h00, 8'h00, 8'h00, 8'hF0, 1, 1, 16'h0);
    runOp(C_BTST, 16'h0062, 3'd2, 0, c, w);
    chk(zOut == 0 && nOut == 1 && w == 0, "R11 bit one", zOut, 0);
    setRegs(8'h00, 8'h00, 8'h00, 8'hF0, 1, 0, 16'h0);
    runOp(C_BTST, 16'h0062, 3'd1, 0, c, w);
    chk(zOut == 1 && nOut == 1 && mem[16'h62] == 8'h04, "R11 bit zero", zOut, 1);
  endtask

  task automatic t_unused();
    int c, w;
    setRegs(8'hA1, 8'hB2, 8'hC3, 8'hF0, 1, 0, 16'hBEEF);
    runOp(4'hF, 16'h0030, 0, 0, c, w);
    chk(c == 2 && w == 0, "R12 timing no write", c, 2);
    chk(aOut == 8'hA1 && xOut == 8'hB2 && yOut == 8'hC3 && pcOut == 16'hBEEF
        && nOut == 1 && zOut == 0, "R12 unchanged", pcOut, 16'hBEEF);
  endtask

  task automatic t_busyStart();
    int c, w;
    mem[16'h30] = 8'h00; mem[16'h31] = 8'h02; mem[16'h205] = 8'h85;
    setRegs(8'h11, 8'h10, 8'h05, 8'hF0, 0, 1, 16'h0);
    runOp(C_LDIND, 16'h0020, 0, 1, c, w);
    chk(aOut == 8'h85 && xOut == 8'h10 && c == 6, "R2 start while busy", xOut, 8'h10);
    @(negedge clk);
    chk(done == 0 && aOut == 8'h85, "R13 single pulse and hold", done, 0);
    @(negedge clk);
    chk(busy == 0 && xOut == 8'h10, "R2 no late start", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_ldind();
    t_stind();
    t_wrap();
    t_xstep();
    t_s2y();
    t_pair();
    t_jtab();
    t_bits();
    t_unused();
    t_busyStart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule